// File: doc/BRIEF.md
# Rate-Programmable Frame Playback Generator

This block imitates the output stream of a channelizer, so that a data-acquisition path can be brought up and checked without converters or an external sample clock. It runs entirely from its own system clock. Two 32-bit on-chip memories hold the playback buffer. One memory holds the real halves of complex samples and the other holds the imaginary halves. Both halves are fetched from the same address to form one 64-bit word. A host write port preloads either memory while playback is stopped.

Once enabled, an internal pacer issues a frame tick every programmed number of clock cycles. The period is limited to the range between the fastest and slowest allowed frame rates. On each tick the block sends one frame on a valid/ready stream:

- A header word comes first. It carries a fixed sync pattern and a running frame count.
- A fixed number of complex words follow. They are read from consecutive buffer addresses.

Each frame starts where the previous one stopped, wrapping at the end of the buffer. A ramp preload therefore shows any lost, repeated or out-of-order word as a break in a constant step. If a tick arrives while a frame is still held up by backpressure, that tick is dropped and a sticky flag records it.

Top module: `frame_player`

## Requirements
- R1: After reset `out_valid`, `out_sop`, `out_eop` and `overrun` are all 0.
- R2: Each frame begins with a header word marked by `out_sop`=1. Its bits [63:32] hold the constant 32'hA5C3_0F5A. Its bits [31:0] hold the frame count, which is 0 for the first frame after enabling and rises by 1 per frame sent.
- R3: After the header come exactly FRAME_WORDS data words. Each has the real-memory word in bits [63:32] and the imaginary-memory word at the same address in bits [31:0]. The addresses rise by one from word to word. Only the last data word has `out_eop`=1, and `out_sop` and `out_eop` are never both 1.
- R4: The first address of each frame is FRAME_WORDS past the first address of the previous frame, modulo 2**ADDR_W. The first frame after enabling starts at address 0.
- R5: The first header is valid in the cycle after `play_en` is first sampled high. After that, headers become valid exactly every P cycles, where P is the clamped period, provided no tick is dropped.
- R6: The period P equals `rate_period`, except that it is raised to PERIOD_MIN when smaller and lowered to PERIOD_MAX when larger.
- R7: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid`=1 and `out_data` unchanged.
- R8: A tick that occurs while a frame is in progress starts no extra frame and sets `overrun`. The flag stays 1 while `play_en` stays high and returns to 0 in the cycle after `play_en` is sampled low. The frame count counts only frames actually sent.
- R9: Host writes (`wr_sel`=1 real, 0 imaginary) take effect only while `play_en`=0. A write attempted during playback leaves the buffer unchanged.
- R10: When `play_en` is sampled low, `out_valid` is 0 from the next cycle on. The next enable restarts with frame count 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback enable; low aborts and rewinds |
| rate_period | input | 32 | Requested clock cycles between frames |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 1 selects real memory, 0 imaginary |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 2*DATA_W | Header or complex word |
| out_sop | output | 1 | Word is the frame header |
| out_eop | output | 1 | Word is the last of the frame |
| overrun | output | 1 | Sticky dropped-tick flag |

## Verification
The overrun case is the hardest to reach. A tick is dropped only when backpressure keeps a frame alive for longer than a whole pacing period. The bench builds that case by holding `out_ready` low for several minimum periods, which pins the first header in place. It then checks three things: the flag is set, the stalled header did not change, and the frames that follow still carry consecutive counts. A second run with pseudo-random ready confirms that plain backpressure shorter than a period never raises the flag.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA
    } play_st_e;

    localparam logic [31:0] SYNC_WORD = 32'hA5C3_0F5A;

endpackage

// File: rtl/pb_pacer.sv
module pb_pacer #(
    parameter int unsigned PERIOD_MIN = 10000,
    parameter int unsigned PERIOD_MAX = 100000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [31:0] period_req,
    output logic        tick
);

    localparam logic [31:0] LO = 32'(PERIOD_MIN);
    localparam logic [31:0] HI = 32'(PERIOD_MAX);

    logic [31:0] cnt_d, cnt_q;
    logic [31:0] per_eff;

    always_comb begin
        if (period_req < LO)      per_eff = LO;
        else if (period_req > HI) per_eff = HI;
        else                      per_eff = period_req;

        tick  = run && (cnt_q == 32'd0);
        cnt_d = cnt_q;
        if (!run)      cnt_d = 32'd0;
        else if (tick) cnt_d = per_eff - 32'd1;
        else           cnt_d = cnt_q - 32'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= 32'd0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HI - 32'd1);                                         // R6

    AST_RELOAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q >= LO - 32'd1));                              // R6

endmodule

// File: rtl/pb_mem.sv
module pb_mem #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata_q <= store[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/frame_player.sv
module frame_player #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned FRAME_WORDS = 256,
    parameter int unsigned PERIOD_MIN  = 10000,
    parameter int unsigned PERIOD_MAX  = 100000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                play_en,
    input  logic [31:0]         rate_period,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*DATA_W-1:0] out_data,
    output logic                out_sop,
    output logic                out_eop,
    output logic                overrun
);
    import pb_pkg::*;

    localparam int unsigned    IDX_W    = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_WORDS - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(FRAME_WORDS);
    localparam int unsigned    LANES    = 2;

    typedef struct packed {
        play_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [31:0]       fcnt;
        logic              ovr;
    } play_regs_t;

    play_regs_t r_d, r_q;

    logic                tick;
    logic                fire;
    logic [ADDR_W-1:0]   raddr;
    logic [DATA_W-1:0]   lane_rd [LANES];

    pb_pacer #(
        .PERIOD_MIN (PERIOD_MIN),
        .PERIOD_MAX (PERIOD_MAX)
    ) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (play_en),
        .period_req (rate_period),
        .tick       (tick)
    );

    // lane 1 = real half (upper), lane 0 = imaginary half (lower)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = wr_en && !play_en && (wr_sel == g[0]);
        pb_mem #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_mem (
            .clk   (clk),
            .we    (lane_we),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (raddr),
            .rdata (lane_rd[g])
        );
    end

    always_comb begin
        out_valid = (r_q.st != ST_IDLE);
        out_sop   = (r_q.st == ST_HEAD);
        out_eop   = (r_q.st == ST_DATA) && (r_q.idx == LAST_IDX);
        overrun   = r_q.ovr;
        case (r_q.st)
            ST_HEAD: out_data = {SYNC_WORD, r_q.fcnt};
            ST_DATA: out_data = {lane_rd[1], lane_rd[0]};
            default: out_data = '0;
        endcase
    end

    always_comb begin
        r_d   = r_q;
        fire  = out_valid && out_ready;
        raddr = r_q.base;
        if (!play_en) begin
            r_d.st   = ST_IDLE;
            r_d.base = '0;
            r_d.addr = '0;
            r_d.idx  = '0;
            r_d.fcnt = '0;
            r_d.ovr  = 1'b0;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (tick) r_d.st = ST_HEAD;
                end
                ST_HEAD: begin
                    if (tick) r_d.ovr = 1'b1;
                    if (fire) begin
                        r_d.st   = ST_DATA;
                        r_d.addr = r_q.base;
                        r_d.idx  = '0;
                        r_d.fcnt = r_q.fcnt + 32'd1;
                    end
                end
                ST_DATA: begin
                    if (tick) r_d.ovr = 1'b1;
                    raddr = fire ? r_q.addr + 1'b1 : r_q.addr;
                    if (fire) begin
                        r_d.addr = r_q.addr + 1'b1;
                        r_d.idx  = r_q.idx + 1'b1;
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st   = ST_IDLE;
                            r_d.base = r_q.base + STEP;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.base <= '0;
            r_q.addr <= '0;
            r_q.idx  <= '0;
            r_q.fcnt <= '0;
            r_q.ovr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !play_en)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));       // R7

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !out_valid);                                               // R10

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && play_en) |=> overrun);                                      // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !play_en)
        (out_valid && out_sop && out_ready) |=> (r_q.fcnt == $past(r_q.fcnt) + 32'd1)); // R2

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sop && out_eop));                                                 // R3

    AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n || !play_en)
        (out_valid && out_eop && out_ready) |=> !out_eop);                      // R3

endmodule

// File: tb/frame_player_tb.sv
module frame_player_tb;

    localparam int AW  = 5;
    localparam int DW  = 32;
    localparam int FW  = 8;
    localparam int PMN = 40;
    localparam int PMX = 200;
    localparam int DEP = 1 << AW;
    localparam logic [31:0] SYNC = 32'hA5C3_0F5A;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            play_en = 1'b0;
    logic [31:0]     rate_period = 32'd0;
    logic            wr_en = 1'b0;
    logic            wr_sel = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [2*DW-1:0] out_data;
    logic            out_sop;
    logic            out_eop;
    logic            overrun;

    frame_player #(
        .ADDR_W      (AW),
        .DATA_W      (DW),
        .FRAME_WORDS (FW),
        .PERIOD_MIN  (PMN),
        .PERIOD_MAX  (PMX)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .play_en     (play_en),
        .rate_period (rate_period),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .overrun     (overrun)
    );

    always #2.5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [65:0] exp_q [$];
    int          fexp = 0;
    int          bexp = 0;
    int          exp_per = 0;
    int          en_cyc = 0;
    logic        first_pend = 1'b0;
    logic        have_last = 1'b0;
    int          last_hdr = 0;
    logic        prev_stall = 1'b0;
    logic [63:0] prev_data = '0;
    logic        prev_hdr_vis = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ramp_re(input int a);
        return 32'd1000 + 32'(a) * 32'd2;
    endfunction
    function automatic logic [31:0] ramp_im(input int a);
        return 32'd50000 + 32'(a) * 32'd2;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // driver: expected frames into the scoreboard queue
    task automatic push_frames(input int n);
        for (int f = 0; f < n; f++) begin
            exp_q.push_back({1'b1, 1'b0, SYNC, 32'(fexp)});
            for (int w = 0; w < FW; w++) begin
                int a;
                a = (bexp + w) % DEP;
                exp_q.push_back({1'b0, (w == FW - 1), ramp_re(a), ramp_im(a)});
            end
            fexp++;
            bexp = (bexp + FW) % DEP;
        end
    endtask

    task automatic host_write(input logic sel, input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_play(input logic [31:0] per, input int eff);
        @(negedge clk);
        rate_period = per;
        exp_per = eff;
        fexp = 0; bexp = 0;
        have_last = 1'b0;
        play_en = 1'b1;
        en_cyc = cyc;
        first_pend = 1'b1;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: drives ready, pops expected items at each transfer
    always @(negedge clk) begin
        if (rst_n) begin
            logic rdy;
            logic hdr_vis;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0:       rdy = 1'b1;
                1:       rdy = lfsr[0];
                default: rdy = 1'b0;
            endcase
            out_ready = rdy;

            if (prev_stall)
                check(out_valid && (out_data == prev_data), "R7 held word", out_data, prev_data);

            hdr_vis = out_valid && out_sop;
            if (hdr_vis && !prev_hdr_vis) begin
                if (first_pend) begin
                    check(cyc - en_cyc == 1, "R5 first header latency", 64'(cyc - en_cyc), 64'd1);
                    first_pend = 1'b0;
                end else if (have_last) begin
                    check(cyc - last_hdr == exp_per, "R5 R6 header spacing",
                          64'(cyc - last_hdr), 64'(exp_per));
                end
                have_last = 1'b1;
                last_hdr = cyc;
            end
            prev_hdr_vis = hdr_vis;

            if (out_valid && rdy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected word", out_data, 64'd0);
                end else begin
                    logic [65:0] e;
                    e = exp_q.pop_front();
                    if (e[65])
                        check(out_sop && !out_eop && out_data == e[63:0], "R2 header",
                              out_data, e[63:0]);
                    else
                        check(!out_sop && out_eop == e[64] && out_data == e[63:0],
                              "R3 R4 data word", {out_data[63:1], out_eop}, {e[63:1], e[64]});
                end
            end
            prev_stall = out_valid && !rdy;
            prev_data  = out_data;
        end
    end

    initial begin
        wait (cyc >= 150000);
        check(1'b0, "watchdog expired", 64'(cyc), 64'd0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_sop && !out_eop && !overrun, "R1 reset state",
              {60'd0, out_valid, out_sop, out_eop, overrun}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !overrun, "R1 after release", {62'd0, out_valid, overrun}, 64'd0);

        // preload both memories with a ramp (R9: allowed while stopped)
        for (int a = 0; a < DEP; a++) begin
            host_write(1'b1, a, ramp_re(a));
            host_write(1'b0, a, ramp_im(a));
        end

        // Phase A: period below min is raised to PMN (R6); wraps the buffer (R4)
        ready_mode = 0;
        start_play(32'd10, PMN);
        push_frames(6);
        wait_empty();
        check(!overrun, "R8 no overrun without stall", {63'd0, overrun}, 64'd0);
        @(negedge clk);
        play_en = 1'b0;
        @(negedge clk);
        check(!out_valid, "R10 stop clears valid", {63'd0, out_valid}, 64'd0);
        repeat (3) @(negedge clk);
        check(!out_valid, "R10 stays idle", {63'd0, out_valid}, 64'd0);

        // Phase B: period above max is lowered (R6), random ready, write ignored (R9)
        ready_mode = 1;
        start_play(32'd5000, PMX);
        push_frames(3);               // counter and pointer restart at 0 (R10)
        host_write(1'b1, 3, 32'hDEAD_BEEF);  // R9: must not land, frame 0 checks addr 3
        host_write(1'b0, 4, 32'hDEAD_BEEF);
        wait_empty();
        check(!overrun, "R8 short stalls no overrun", {63'd0, overrun}, 64'd0);
        @(negedge clk);
        play_en = 1'b0;
        @(negedge clk);
        check(!out_valid, "R10 stop after B", {63'd0, out_valid}, 64'd0);

        // Phase C: long stall drops ticks (R8)
        ready_mode = 2;
        start_play(32'd40, PMN);
        push_frames(2);
        repeat (120) @(negedge clk);
        check(overrun == 1'b1, "R8 overrun set", {63'd0, overrun}, 64'd1);
        check(out_valid && out_sop && out_data == {SYNC, 32'd0}, "R7 R8 stalled header",
              out_data, {SYNC, 32'd0});
        have_last = 1'b0;             // spacing disturbed by the stall
        ready_mode = 0;
        wait_empty();
        check(overrun == 1'b1, "R8 overrun sticky", {63'd0, overrun}, 64'd1);
        @(negedge clk);
        play_en = 1'b0;
        @(negedge clk);
        check(!overrun && !out_valid, "R8 R10 cleared on stop",
              {62'd0, overrun, out_valid}, 64'd0);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule